// File: doc/BRIEF.md
# DMA Interrupt Status and Masking Unit

This block gathers the interrupt events that the channel engines of a DMA controller raise, and presents them to software through a small register space. Five event classes are tracked, each with one bit per channel: transfer done, block done, source transaction, destination transaction and error. A one-cycle pulse on an event input latches the matching raw bit. The raw bit stays set until software acknowledges it by writing a one to that bit of the class's clear register.

Each class has a mask register, and a mask bit of one enables that channel's interrupt. The status view of a class is formed from raw and mask as it is read; it is never held in its own storage. A summary register gathers, per class, whether any status bit is active, and the single interrupt output is the OR of the summary bits. Mask writes and channel-enable writes carry their own per-channel write-enable byte, so software can change chosen channel bits without reading the register first. The channel-enable register also drives an output vector to the channel engines.

Registers are word-addressed through five-bit addresses. Address bits [4:3] select the view: 0 raw, 1 status, 2 mask, 3 clear. Address bits [2:0] select the class: 0 transfer done, 1 block done, 2 source transaction, 3 destination transaction, 4 error. Inside view 0, index 5 is the summary register and index 6 is the channel-enable register. Reads are combinational. Unused read bits and unmapped addresses read as zero.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset all raw bits, mask bits and channel-enable bits read zero, and `irq` is low.
- R2: An event pulse on `evt[c][n]` sets raw bit n of class c at the next clock edge. The bit is read at address c in bits [n], and it holds until it is cleared.
- R3: A write of data d to address 24+c clears every raw bit of class c where d[n] is one, and leaves the other raw bits unchanged. The clear addresses always read as zero.
- R4: When an event on a bit arrives in the same cycle as a clear of that same bit, the raw bit remains set.
- R5: Status of class c, read at address 8+c, equals the raw bits AND the mask bits of that class.
- R6: A write to mask address 16+c updates mask bit n to wr_data[n] only where wr_data[8+n] is one. Every other mask bit keeps its value. The mask reads back at address 16+c in bits [7:0].
- R7: A write to address 6 updates channel-enable bit n to wr_data[n] only where wr_data[8+n] is one. The register reads at address 6 and drives `ch_en`.
- R8: Summary (address 5) bit c is one exactly when class c has any status bit set. The bit order is 0 transfer done, 1 block done, 2 source transaction, 3 destination transaction, 4 error.
- R9: `irq` is high exactly when any summary bit is set.
- R10: Writes to raw addresses 0-4, to status addresses 8-12 and to the summary address 5 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 16 | Write data: [15:8] channel write enables, [7:0] values or clear bits |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Combinational read data |
| evt | input | 5x8 | Event pulses, evt[class][channel] |
| ch_en | output | 8 | Channel-enable register contents |
| irq | output | 1 | Combined interrupt request |

## Verification
The two functions that can coincide are an event pulse from a channel engine and a software clear of the same raw bit. The directed test pulses a channel's transfer-done event in the very cycle that its clear register is written with that bit. It expects the raw bit to survive, and it expects the bit to drop only when a later clear arrives with no event. The random phase fires events and clears together on overlapping bits every cycle. After each step it compares every view with a bench model in which the event takes priority over the clear.

// File: rtl/dic_pkg.sv
package dic_pkg;
    localparam int NUM_CLS = 5;
    localparam int ADDR_W  = 5;
    localparam int WE_LSB  = 8;

    typedef enum logic [1:0] {
        GRP_RAW  = 2'd0,
        GRP_STAT = 2'd1,
        GRP_MASK = 2'd2,
        GRP_CLR  = 2'd3
    } grp_e;

    localparam logic [2:0] IDX_SUMM = 3'd5;
    localparam logic [2:0] IDX_CHEN = 3'd6;
endpackage

// File: rtl/dic_wen_reg.sv
module dic_wen_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] we,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr)
            q <= (q & ~we) | (val & we);
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_UNSEL_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr || !we[i]) |=> $stable(q[i]));                       // R6
        AST_SEL_BIT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && we[i]) |=> (q[i] == $past(val[i])));               // R6
    end
endmodule

// File: rtl/dic_class_bank.sv
module dic_class_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic           clr_wr,
    input  logic [NCH-1:0] clr_bits,
    input  logic           msk_wr,
    input  logic [NCH-1:0] msk_we,
    input  logic [NCH-1:0] msk_val,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] stat,
    output logic           any
);
    logic [NCH-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)
            raw <= '0;
        else
            raw <= (raw & ~clr_eff) | evt;
    end

    dic_wen_reg #(.W(NCH)) u_mask (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (msk_wr),
        .we   (msk_we),
        .val  (msk_val),
        .q    (mask)
    );

    assign stat = raw & mask;
    assign any  = |stat;

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> raw[i]);                                       // R4
        AST_CLR_DROPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_bits[i] && !evt[i]) |=> !raw[i]);          // R3
        AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[i] && !(clr_wr && clr_bits[i])) |=> $stable(raw[i])); // R2
    end
endmodule

// File: rtl/dic_read_mux.sv
module dic_read_mux import dic_pkg::*; #(
    parameter int NCH  = 8,
    parameter int RD_W = 32
) (
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NUM_CLS-1:0][NCH-1:0]   raw,
    input  logic [NUM_CLS-1:0][NCH-1:0]   stat,
    input  logic [NUM_CLS-1:0][NCH-1:0]   mask,
    input  logic [NUM_CLS-1:0]            summ,
    input  logic [NCH-1:0]                chen,
    output logic [RD_W-1:0]               rd_data
);
    logic [2:0] idx;
    logic       cls_ok;

    assign idx    = rd_addr[2:0];
    assign cls_ok = (int'(idx) < NUM_CLS);

    always_comb begin
        rd_data = '0;
        unique case (grp_e'(rd_addr[ADDR_W-1:3]))
            GRP_RAW: begin
                if (cls_ok)
                    rd_data[NCH-1:0] = raw[idx];
                else if (idx == IDX_SUMM)
                    rd_data[NUM_CLS-1:0] = summ;
                else if (idx == IDX_CHEN)
                    rd_data[NCH-1:0] = chen;
            end
            GRP_STAT: if (cls_ok) rd_data[NCH-1:0] = stat[idx];
            GRP_MASK: if (cls_ok) rd_data[NCH-1:0] = mask[idx];
            GRP_CLR:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl import dic_pkg::*; #(
    parameter int NUM_CH = 8,
    parameter int RD_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WE_LSB+NUM_CH-1:0]      wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [RD_W-1:0]               rd_data,
    input  logic [NUM_CLS-1:0][NUM_CH-1:0] evt,
    output logic [NUM_CH-1:0]             ch_en,
    output logic                          irq
);
    logic [NUM_CLS-1:0][NUM_CH-1:0] raw_all;
    logic [NUM_CLS-1:0][NUM_CH-1:0] mask_all;
    logic [NUM_CLS-1:0][NUM_CH-1:0] stat_all;
    logic [NUM_CLS-1:0]             summ;
    logic [NUM_CH-1:0]              wr_we;
    logic [NUM_CH-1:0]              wr_val;
    logic [1:0]                     wr_grp;
    logic [2:0]                     wr_idx;
    logic                           chen_wr;

    assign wr_we   = wr_data[WE_LSB+NUM_CH-1:WE_LSB];
    assign wr_val  = wr_data[NUM_CH-1:0];
    assign wr_grp  = wr_addr[ADDR_W-1:3];
    assign wr_idx  = wr_addr[2:0];
    assign chen_wr = wr_en && (wr_grp == GRP_RAW) && (wr_idx == IDX_CHEN);

    for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
        logic clr_wr_k;
        logic msk_wr_k;
        assign clr_wr_k = wr_en && (wr_grp == GRP_CLR)  && (wr_idx == 3'(k));
        assign msk_wr_k = wr_en && (wr_grp == GRP_MASK) && (wr_idx == 3'(k));

        dic_class_bank #(.NCH(NUM_CH)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt[k]),
            .clr_wr  (clr_wr_k),
            .clr_bits(wr_val),
            .msk_wr  (msk_wr_k),
            .msk_we  (wr_we),
            .msk_val (wr_val),
            .raw     (raw_all[k]),
            .mask    (mask_all[k]),
            .stat    (stat_all[k]),
            .any     (summ[k])
        );
    end

    dic_wen_reg #(.W(NUM_CH)) u_chen (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (chen_wr),
        .we   (wr_we),
        .val  (wr_val),
        .q    (ch_en)
    );

    dic_read_mux #(.NCH(NUM_CH), .RD_W(RD_W)) u_rdmux (
        .rd_addr(rd_addr),
        .raw    (raw_all),
        .stat   (stat_all),
        .mask   (mask_all),
        .summ   (summ),
        .chen   (ch_en),
        .rd_data(rd_data)
    );

    assign irq = |summ;

    AST_IRQ_OFF_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_all == '0) |-> !irq);                                   // R9
    AST_IRQ_OFF_WHEN_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_all == '0) |-> !irq);                                    // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (raw_all == '0 && mask_all == '0 && ch_en == '0)); // R1
endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [4:0][7:0] evt = '0;
    logic [7:0]  ch_en;
    logic        irq;

    logic [7:0] m_raw  [5];
    logic [7:0] m_mask [5];
    logic [7:0] m_chen;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dma_irq_ctrl u_dma_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt(evt), .ch_en(ch_en), .irq(irq)
    );

    function automatic logic [4:0] f_summary();
        logic [4:0] s;
        for (int k = 0; k < 5; k++) s[k] = |(m_raw[k] & m_mask[k]);
        return s;
    endfunction

    task automatic drive(input bit w, input logic [4:0] a, input logic [15:0] d,
                         input logic [4:0][7:0] e);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; evt = e;
        @(posedge clk);
        for (int k = 0; k < 5; k++) begin
            logic [7:0] clr;
            clr = (w && a[4:3] == 2'd3 && a[2:0] == 3'(k)) ? d[7:0] : 8'h00;
            m_raw[k] = (m_raw[k] & ~clr) | e[k];
            if (w && a[4:3] == 2'd2 && a[2:0] == 3'(k))
                m_mask[k] = (m_mask[k] & ~d[15:8]) | (d[7:0] & d[15:8]);
        end
        if (w && a == 5'd6)
            m_chen = (m_chen & ~d[15:8]) | (d[7:0] & d[15:8]);
        #1;
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic check_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        n_tests++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_all();
        for (int k = 0; k < 5; k++) begin
            check_reg(5'(k),      {24'h0, m_raw[k]},             "R2 raw");
            check_reg(5'(8 + k),  {24'h0, m_raw[k] & m_mask[k]}, "R5 status");
            check_reg(5'(16 + k), {24'h0, m_mask[k]},            "R6 mask");
            check_reg(5'(24 + k), 32'h0,                         "R3 clear reads zero");
        end
        check_reg(5'd5, {27'h0, f_summary()}, "R8 summary");
        check_reg(5'd6, {24'h0, m_chen},      "R7 chen reg");
        n_tests++;
        if (ch_en !== m_chen) begin
            n_fail++;
            $display("FAIL R7 ch_en actual=%h expected=%h", ch_en, m_chen);
        end
        check_bit(irq, |f_summary(), "R9 irq");
    endtask

    function automatic logic [4:0][7:0] one_evt(input int c, input int n);
        logic [4:0][7:0] e;
        e = '0;
        e[c][n] = 1'b1;
        return e;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 5; k++) begin m_raw[k] = '0; m_mask[k] = '0; end
        m_chen = '0;
        repeat (3) @(posedge clk);
        // events during reset must not stick
        @(negedge clk); evt = '1;
        @(negedge clk); evt = '0; rst_n = 1'b1;
        #1;
        // R1: reset state
        check_reg(5'd0,  32'h0, "R1 raw after reset");
        check_reg(5'd20, 32'h0, "R1 mask after reset");
        check_reg(5'd6,  32'h0, "R1 chen after reset");
        check_bit(irq, 1'b0, "R1 irq after reset");

        // R2: event latches and holds
        drive(0, 5'd0, 16'h0, one_evt(0, 3));
        check_reg(5'd0, 32'h08, "R2 event latched");
        drive(0, 5'd0, 16'h0, '0);
        drive(0, 5'd0, 16'h0, '0);
        check_reg(5'd0, 32'h08, "R2 raw holds");
        check_bit(irq, 1'b0, "R9 irq low while masked");

        // R5/R8/R9: enable mask bit 3 of class 0
        drive(1, 5'd16, 16'h0808, '0);
        check_reg(5'd8, 32'h08, "R5 status raw and mask");
        check_reg(5'd5, 32'h01, "R8 summary class0");
        check_bit(irq, 1'b1, "R9 irq high");

        // R6: only enabled mask bit changes
        drive(1, 5'd16, 16'h01FF, '0);
        check_reg(5'd16, 32'h09, "R6 selective mask write");

        // R4: event and clear of the same bit in one cycle
        drive(1, 5'd24, 16'h0008, one_evt(0, 3));
        check_reg(5'd0, 32'h08, "R4 event beats clear");
        drive(1, 5'd24, 16'h0008, '0);
        check_reg(5'd0, 32'h00, "R3 clear drops raw");
        check_bit(irq, 1'b0, "R9 irq low after clear");

        // R10: writes to read-only addresses are ignored
        drive(0, 5'd0, 16'h0, one_evt(1, 5));
        drive(1, 5'd1, 16'hFFFF, '0);
        drive(1, 5'd9, 16'hFFFF, '0);
        drive(1, 5'd5, 16'hFFFF, '0);
        check_reg(5'd1,  32'h20, "R10 raw write ignored");
        check_reg(5'd17, 32'h00, "R10 mask untouched");
        check_reg(5'd6,  32'h00, "R10 chen untouched");

        // R7: channel enable selective write
        drive(1, 5'd6, 16'hF0A5, '0);
        check_reg(5'd6, 32'hA0, "R7 chen selective write");
        check_bit(ch_en[7], 1'b1, "R7 ch_en port bit7");

        // R8: error class lands in summary bit 4
        drive(0, 5'd0, 16'h0, one_evt(4, 0));
        drive(1, 5'd20, 16'h0101, '0);
        check_reg(5'd5, 32'h10, "R8 summary error class");
        check_all();

        // random phase
        for (int it = 0; it < 400; it++) begin
            logic [4:0][7:0] e;
            logic [4:0]  a;
            logic [15:0] d;
            bit          w;
            int          op;
            for (int k = 0; k < 5; k++)
                e[k] = 8'($urandom & $urandom & $urandom);
            op = int'($urandom % 5);
            d  = 16'($urandom);
            w  = 1'b1;
            case (op)
                0: a = 5'(16 + ($urandom % 5));
                1: a = 5'(24 + ($urandom % 5));
                2: a = 5'd6;
                3: begin
                    a = {1'b0, 1'($urandom), 3'($urandom)};
                    if (a == 5'd6) a = 5'd5;
                end
                default: begin w = 1'b0; a = '0; end
            endcase
            drive(w, a, d, e);
            check_all();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule